// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block is a small bank of event counters that sits beside a DRAM controller and measures its traffic. Four counters share one register port. Slot 0 is tied to the clock and counts cycles. Slots 1 to 3 each pick one event out of a strobe vector with an 8-bit code, for example 0x04 for a read access, 0x05 for a write access, 0x21 for a write command, 0x32 for an activate or 0x37 for a refresh. The controller raises bit `code` of the strobe vector for one clock each time that event happens.

The cycle counter paces the whole bank, and a finite-state machine with three states does this work:
- `ST_HALT`: the bank is stopped because the cycle counter is disabled.
- `ST_RUN`: the bank is counting.
- `ST_FROZEN`: the cycle counter has overflowed. Every counter is held and the interrupt is raised.

The transitions are these:
- `ST_HALT` goes to `ST_RUN` on a write to control register 0 with the enable bit set.
- `ST_RUN` goes to `ST_HALT` on a write to control register 0 with the enable bit clear. A write to control register 0 with the enable bit set leaves the machine in `ST_RUN`.
- `ST_RUN` goes to `ST_FROZEN` when the cycle counter wraps.
- `ST_FROZEN` goes to `ST_RUN` or to `ST_HALT` on any write to control register 0. The enable bit of that write picks the target.

The event counters wrap without raising an interrupt. Software that samples them at least once per cycle-counter period therefore loses nothing.

Top module: `memperf_bank`

## Requirements
- R1: After reset every control register and every count reads zero and `irq` is low.
- R2: Control register n is at byte address 4*n and count n is at byte address 0x20+4*n, for n from 0 to 3. Reads of any other address, including misaligned ones and 0x10 to 0x1F, return zero. Writes to any other address have no effect.
- R3: The control word has these fields:
  - bit 0: sticky overflow flag, read-only.
  - bit 1: clear request. It always reads back as 0.
  - bit 2: enable.
  - bits 31:24: event code.
  - All other bits read as 0.
- R4: A control write with bit 1 set zeroes the count at the clock edge of the write. A control write with bit 1 clear keeps the count, and the counter does not increment in the write cycle. An enable written at edge k first counts at edge k+1. A write of zero followed by a write of enable with clear is accepted.
- R5: Counter 0 increments once per clock while it is enabled with code 0x00. With any other code it does not increment.
- R6: Counter 1, 2 or 3, when enabled with code c not equal to 0x00 and with the bank running, increments on each edge at which strobe bit c is high. With code 0x00 it never increments.
- R7: While the counter 0 enable is clear, no count in the bank changes except through a clear request.
- R8: Counters 1 to 3 are CNT_W bits wide. Each one wraps from all-ones to zero, sets its overflow flag and keeps counting. Its overflow does not raise `irq`.
- R9: When counter 0 wraps, it reads zero, its overflow flag sets, `irq` rises, and no count advances until counter 0's control register is written.
- R10: Any write to control register 0 clears its overflow flag, drops `irq` at the next edge and releases the freeze. If that write has the enable bit set, counter 0 has counted N after N further clocks.
- R11: An overflow flag stays set until its own control register is written. Writes to other registers leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | 6 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_strobe | input | 256 | Event strobes, one bit per event code |
| irq | output | 1 | Level interrupt, high while the bank is frozen |

## Verification
The assertions take for granted that the strobe vector, the address and the write strobe always carry known values. They also take for granted that the only thing that moves a count is a clear request or an increment, so every "no change" check is gated on the absence of a write. The stimulus changes all inputs only on the falling clock edge and from defined values. It mixes random strobe vectors and random control writes with directed sequences, and it restarts the cycle counter often enough that event-counter wraps can be seen before a freeze.

// File: rtl/memperf_pkg.sv
`timescale 1ns/1ps
package memperf_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int SEL_W   = 8;
    localparam int EVT_N   = 1 << SEL_W;
    localparam int OVF_BIT = 0;
    localparam int CLR_BIT = 1;
    localparam int EN_BIT  = 2;
    localparam int SEL_LSB = DATA_W - SEL_W;
    localparam logic [SEL_W-1:0] CYCLE_CODE = '0;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } bank_st_e;
endpackage

// File: rtl/memperf_fsm.sv
`timescale 1ns/1ps
// Global run/freeze control paced by the cycle counter.
module memperf_fsm
    import memperf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr0,
    input  logic wr0_en,
    input  logic wrap0,
    output logic run,
    output logic irq
);
    bank_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT:   if (wr0 && wr0_en) st_d = ST_RUN;
            ST_RUN: begin
                if (wr0)        st_d = wr0_en ? ST_RUN : ST_HALT;
                else if (wrap0) st_d = ST_FROZEN;
            end
            ST_FROZEN: if (wr0) st_d = wr0_en ? ST_RUN : ST_HALT;
            default:   st_d = ST_HALT;
        endcase
    end

    always_comb begin
        run = 1'b0;
        irq = 1'b0;
        unique case (st_q)
            ST_RUN:    run = 1'b1;
            ST_FROZEN: irq = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/memperf_ctr.sv
`timescale 1ns/1ps
// One counter slot: control fields, count, sticky overflow.
module memperf_ctr #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             hit,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic [SEL_W-1:0] sel,
    output logic             en,
    output logic             ovf,
    output logic             wrap
);
    logic inc;

    assign inc  = run & en & hit & ~wr;
    assign wrap = inc & (&count);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            sel   <= '0;
            en    <= 1'b0;
            ovf   <= 1'b0;
        end else if (wr) begin
            en  <= wr_en;
            sel <= wr_sel;
            ovf <= 1'b0;
            if (wr_clr) count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
            if (&count) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/memperf_regdec.sv
`timescale 1ns/1ps
// Address decode: write strobes per slot and the read mux.
module memperf_regdec
    import memperf_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int CNT_W = 32
) (
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [N_CTR-1:0][DATA_W-1:0]  ctrl_rd,
    input  logic [N_CTR-1:0][CNT_W-1:0]   cnt_rd,
    output logic [N_CTR-1:0]              wr_hit,
    output logic [DATA_W-1:0]             reg_rdata
);
    logic [1:0] slot;
    logic       slot_ok;
    logic       cnt_region;

    assign slot       = reg_addr[3:2];
    assign cnt_region = reg_addr[5];
    assign slot_ok    = (reg_addr[4] == 1'b0) && (reg_addr[1:0] == 2'b00)
                        && (int'(slot) < N_CTR);

    always_comb begin
        wr_hit    = '0;
        reg_rdata = '0;
        for (int i = 0; i < N_CTR; i++) begin
            if (slot_ok && int'(slot) == i) begin
                wr_hit[i] = reg_wr & ~cnt_region;
                reg_rdata = cnt_region ? DATA_W'(cnt_rd[i]) : ctrl_rd[i];
            end
        end
    end
endmodule

// File: rtl/memperf_bank.sv
`timescale 1ns/1ps
// Performance counter bank top.
module memperf_bank
    import memperf_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_N-1:0]  evt_strobe,
    output logic              irq
);
    logic [N_CTR-1:0][SEL_W-1:0]  sel_q;
    logic [N_CTR-1:0][CNT_W-1:0]  cnt_all;
    logic [N_CTR-1:0][DATA_W-1:0] ctrl_rd;
    logic [N_CTR-1:0]             en_all, ovf_all, wrap_all, wr_hit, hit;
    logic                         run;
    logic                         wdata_unused;
    logic                         wrap_unused;

    assign wdata_unused = ^{reg_wdata[SEL_LSB-1:EN_BIT+1], reg_wdata[OVF_BIT]};
    assign wrap_unused  = ^wrap_all[N_CTR-1:1];

    memperf_regdec #(.N_CTR(N_CTR), .CNT_W(CNT_W)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ctrl_rd   (ctrl_rd),
        .cnt_rd    (cnt_all),
        .wr_hit    (wr_hit),
        .reg_rdata (reg_rdata)
    );

    memperf_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr0    (wr_hit[0]),
        .wr0_en (reg_wdata[EN_BIT]),
        .wrap0  (wrap_all[0]),
        .run    (run),
        .irq    (irq)
    );

    for (genvar g = 0; g < N_CTR; g++) begin : g_slot
        if (g == 0) begin : g_cyc
            assign hit[g] = (sel_q[g] == CYCLE_CODE);
        end else begin : g_evt
            assign hit[g] = (sel_q[g] != CYCLE_CODE) && evt_strobe[sel_q[g]];
        end

        assign ctrl_rd[g] = {sel_q[g], {(SEL_LSB-EN_BIT-1){1'b0}},
                             en_all[g], 1'b0, ovf_all[g]};

        memperf_ctr #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_hit[g]),
            .wr_en  (reg_wdata[EN_BIT]),
            .wr_clr (reg_wdata[CLR_BIT]),
            .wr_sel (reg_wdata[SEL_LSB +: SEL_W]),
            .hit    (hit[g]),
            .run    (run),
            .count  (cnt_all[g]),
            .sel    (sel_q[g]),
            .en     (en_all[g]),
            .ovf    (ovf_all[g]),
            .wrap   (wrap_all[g])
        );
    end
endmodule

// File: rtl/memperf_bank_chk.sv
`timescale 1ns/1ps
module memperf_bank_chk
    import memperf_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int CNT_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_wr,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_rdata,
    input logic                         irq,
    input logic [N_CTR-1:0][CNT_W-1:0]  cnt_all,
    input logic [N_CTR-1:0]             en_all,
    input logic [N_CTR-1:0]             ovf_all
);
    logic [N_CTR-1:0] wmask;

    always_comb begin
        wmask = '0;
        for (int i = 0; i < N_CTR; i++)
            if (reg_wr && reg_addr[5:4] == 2'b00 && reg_addr[1:0] == 2'b00
                && int'(reg_addr[3:2]) == i)
                wmask[i] = 1'b1;
    end

    // R9: frozen bank holds every count
    a_r9_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> $stable(cnt_all));

    // R9: interrupt rises exactly with a cycle-counter wrap
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt_all[0] == '0 && ovf_all[0]));

    // R7: halted bank holds every count
    a_r7_halt_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_all[0] && !reg_wr) |=> $stable(cnt_all));

    // R10: writing control 0 releases the interrupt
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        wmask[0] |=> !irq);

    // R8: event counter overflow means a wrap to zero
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_all[1]) |-> (cnt_all[1] == '0));

    // R11: overflow flags persist unless their own register is written
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ovf_all & ~wmask)) |=>
            ((ovf_all & $past(ovf_all & ~wmask)) == $past(ovf_all & ~wmask)));

    // R3: clear request bit never reads back set
    a_r3_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[5] == 1'b0) |-> (reg_rdata[1] == 1'b0));
endmodule

bind memperf_bank memperf_bank_chk #(.N_CTR(N_CTR), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .cnt_all   (cnt_all),
    .en_all    (en_all),
    .ovf_all   (ovf_all)
);

// File: tb/memperf_bank_test.sv
`timescale 1ns/1ps
module memperf_bank_test;
    localparam int CW   = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [255:0] evt = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    memperf_bank #(.N_CTR(4), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt), .irq(irq)
    );

    // reference model of the requirements
    int       m_cnt [4];
    bit       m_en  [4];
    bit [7:0] m_sel [4];
    bit       m_ovf [4];
    int       m_st;
    bit       m_wv, m_run, m_wrap0;
    int       m_wi;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 4; n++) begin
                m_cnt[n] = 0; m_en[n] = 0; m_sel[n] = 0; m_ovf[n] = 0;
            end
            m_st = 0;
        end else begin
            m_wv = reg_wr && reg_addr[5:4] == 2'b00 && reg_addr[1:0] == 2'b00;
            m_wi = int'(reg_addr[3:2]);
            m_run = (m_st == 1);
            m_wrap0 = 0;
            for (int n = 0; n < 4; n++) begin
                if (m_wv && m_wi == n) begin
                    m_en[n] = reg_wdata[2];
                    m_sel[n] = reg_wdata[31:24];
                    m_ovf[n] = 0;
                    if (reg_wdata[1]) m_cnt[n] = 0;
                end else if (m_run && m_en[n] &&
                             (n == 0 ? m_sel[n] == 0 : (m_sel[n] != 0 && evt[m_sel[n]]))) begin
                    if (m_cnt[n] == MAXV) begin
                        m_cnt[n] = 0; m_ovf[n] = 1;
                        if (n == 0) m_wrap0 = 1;
                    end else m_cnt[n]++;
                end
            end
            if (m_wv && m_wi == 0) m_st = reg_wdata[2] ? 1 : 0;
            else if (m_st == 1 && m_wrap0) m_st = 2;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [255:0] ev(int code);
        logic [255:0] v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl(int n);
        return {m_sel[n], 21'b0, m_en[n], 1'b0, m_ovf[n]};
    endfunction

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(bit wr, logic [5:0] a, logic [31:0] d, logic [255:0] e);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt = e;
    endtask

    task automatic wr_ctrl(int n, logic [31:0] d);
        step(1'b1, 6'(4*n), d, '0);
    endtask

    task automatic idle(int k, logic [255:0] e);
        for (int i = 0; i < k; i++) step(1'b0, 6'd0, 32'd0, e);
    endtask

    task automatic idle_rand(int k);
        for (int i = 0; i < k; i++)
            step(1'b0, 6'd0, 32'd0, {8{$urandom()}});
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        reg_addr = a; #0.2; d = reg_rdata;
    endtask

    task automatic expect_reg(string req, logic [5:0] a, logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b0; evt = '0;
        rd(a, d);
        cmp(req, $sformatf("addr %h", a), d, exp);
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b0; evt = '0;
        for (int n = 0; n < 4; n++) begin
            rd(6'(4*n), d);
            cmp(req, $sformatf("ctrl%0d", n), d, exp_ctrl(n));
            rd(6'(32 + 4*n), d);
            cmp(req, $sformatf("count%0d", n), d, 32'(m_cnt[n]));
        end
        cmp(req, "irq", {31'b0, irq}, {31'b0, m_st == 2});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [8];
        codes = '{8'h00, 8'h04, 8'h05, 8'h20, 8'h21, 8'h31, 8'h32, 8'h37};
        void'($urandom(32'd7331));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_all("R1");

        // R2 unmapped addresses
        expect_reg("R2", 6'h10, 32'h0);
        expect_reg("R2", 6'h31, 32'h0);
        step(1'b1, 6'h10, 32'hFFFF_FFFF, '0);
        step(1'b1, 6'h06, 32'hFFFF_FFFF, '0);
        expect_reg("R2", 6'h04, 32'h0);
        check_all("R2");

        // R3 field layout: undefined bits, clear and overflow read as zero
        wr_ctrl(1, 32'h04FF_FFFF);
        expect_reg("R3", 6'h04, 32'h0400_0004);

        // R7 bank halted while counter 0 disabled
        idle(10, ev(4));
        expect_reg("R7", 6'h24, 32'h0);
        check_all("R7");

        // R5 counter 0 with a non-cycle code does not count
        wr_ctrl(0, 32'h0500_0006);
        idle(10, '0);
        expect_reg("R5", 6'h20, 32'h0);
        wr_ctrl(0, 32'h0000_0006);
        idle(20, '0);
        expect_reg("R5", 6'h20, 32'd20);
        check_all("R5");

        // R6 event selection with random strobes; code 0 never counts on slot 3
        wr_ctrl(0, 32'h0000_0006);
        wr_ctrl(2, 32'h2100_0006);
        wr_ctrl(3, 32'h0000_0006);
        idle_rand(60);
        expect_reg("R6", 6'h2C, 32'h0);
        check_all("R6");

        // R4 write without clear holds, with clear zeroes, disable then enable
        wr_ctrl(0, 32'h0000_0006);
        wr_ctrl(2, 32'h2100_0004);
        check_all("R4");
        wr_ctrl(2, 32'h0000_0000);
        wr_ctrl(2, 32'h2100_0006);
        expect_reg("R4", 6'h28, 32'h0);
        idle_rand(20);
        check_all("R4");

        // R8 event counter wraps silently
        wr_ctrl(0, 32'h0000_0006);
        wr_ctrl(1, 32'h0400_0006);
        idle(100, ev(4));
        wr_ctrl(0, 32'h0000_0006);
        idle(100, ev(4));
        wr_ctrl(0, 32'h0000_0006);
        idle(100, ev(4));
        expect_reg("R8", 6'h24, 32'd44);
        expect_reg("R8", 6'h04, 32'h0400_0005);
        check_all("R8");

        // R11 overflow flag sticky across other writes
        wr_ctrl(2, 32'h2100_0004);
        expect_reg("R11", 6'h04, 32'h0400_0005);
        wr_ctrl(1, 32'h0400_0004);
        expect_reg("R11", 6'h04, 32'h0400_0004);
        check_all("R11");

        // R9 cycle counter overflow freezes the bank
        wr_ctrl(0, 32'h0000_0006);
        idle_rand(260);
        expect_reg("R9", 6'h20, 32'h0);
        expect_reg("R9", 6'h00, 32'h0000_0005);
        check_all("R9");
        idle_rand(20);
        check_all("R9");

        // R10 release and restart
        wr_ctrl(0, 32'h0000_0000);
        check_all("R10");
        wr_ctrl(0, 32'h0000_0006);
        idle(5, '0);
        expect_reg("R10", 6'h20, 32'd5);
        check_all("R10");

        // random mix of control writes and strobes
        for (int i = 0; i < 600; i++) begin
            if (($urandom() % 8) == 0) begin
                int n = int'($urandom() % 4);
                logic [7:0] c = (($urandom() % 4) == 0) ? 8'($urandom()) : codes[$urandom() % 8];
                wr_ctrl(n, {c, 21'($urandom()), 3'($urandom())});
            end else begin
                step(1'b0, 6'd0, 32'd0, {8{$urandom()}});
            end
            if ((i % 30) == 29) check_all("R6");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule